// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as two outputs, a normal request (`irq_o`) and a fast request (`fiq_o`). Each line passes through a two-stage synchronizer. It is then optionally inverted and detected either as a latched rising edge or as a live level. Each line can be masked, and it is steered to one of the two outputs. A two-bit global mask gates each output as a whole.

Software reaches the block over a simple synchronous register bus. A write takes effect on the clock edge that samples it. Read data is registered and appears on the edge that samples the read. Among the sources that are pending, enabled and steered to the normal output, a priority table picks a winner. The smallest 8-bit value wins, and the lower source number wins a tie. A vector register reports the winner's number. When clear-on-read is armed, reading the vector register also clears the latched pending bit of the reported source, so an interrupt handler can acknowledge the source with that single read.

Top module: `prio_intc`

## Requirements
- R1: After reset every register reads 0, both outputs are low, and the vector register (word 7) reads 0x80000000.
- R2: A source whose bit in the enable register (word 0) is 0 drives neither output and is never reported as the vector. Its pending bit still latches and is visible in the pending register (word 4).
- R3: A 1 in the polarity register (word 1) inverts that source's input before detection, so the source is active low.
- R4: In edge mode (bit clear in the mode register, word 2), a low-to-high transition of the adjusted input sets a pending bit. The bit stays set after the input falls. Writing 1 to that bit of the pending register clears it.
- R5: In level mode (bit set in word 2), the pending bit follows the adjusted input, one register stage later. Clearing it has no effect.
- R6: A 1 in the route register (word 3) sends the source to `irq_o`, and a 0 sends it to `fiq_o`. Each output is high when any enabled, pending source is routed to it.
- R7: Priorities are 8 bits, with 0 the highest. They are packed four per word starting at word 8: source s sits in word 8+s/4, bits 8*(s%4)+7 down to 8*(s%4). The vector register reports the IRQ-routed, enabled, pending source with the smallest value.
- R8: When priority values are equal, the lower source number wins.
- R9: When no IRQ-routed, enabled, pending source exists, the vector register reads 0x80000000. Otherwise it reads the source number in its low bits, with bit 31 clear.
- R10: When bit 31 of the vector-control register (word 6) is 1, a read of the vector register clears the pending bit of the source it reports. When that bit is 0, the read clears nothing.
- R11: In the global mask register (word 5), bit 0 enables `irq_o` and bit 1 enables `fiq_o`. An output whose bit is 0 stays low.
- R12: An input change reaches `irq_o` or `fiq_o` on the 4th rising clock edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw interrupt request lines |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
A source input takes two synchronizer edges and one pending edge, then one output register edge. `irq_o` and `fiq_o` therefore move on the 4th edge after a change, and the bench waits exactly four falling edges before it samples them. It also samples once after three edges to confirm that nothing moves early. A register write is in effect after its sampling edge, and an output that depends on it moves one edge later, so output checks after a write wait two edges. For each read, the driver pushes the expected word into a queue. A monitor pops that word at the falling edge that follows the read's sampling edge, which is the cycle in which the registered read data is valid.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W = 32;

  // word offsets on the register bus
  localparam int OFS_EN    = 0;
  localparam int OFS_POL   = 1;
  localparam int OFS_MODE  = 2;
  localparam int OFS_ROUTE = 3;
  localparam int OFS_PEND  = 4;
  localparam int OFS_GMASK = 5;
  localparam int OFS_VCTRL = 6;
  localparam int OFS_VEC   = 7;
  localparam int OFS_PRIO  = 8;
endpackage

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int NUM_SRC = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] mode_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
  logic [NUM_SRC-1:0] adj, prev_q, rise, pend_q, pend_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= src_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= adj;
    end
  end

  assign adj  = sync_q[SYNC_STAGES-1] ^ pol_i;
  assign rise = adj & ~prev_q;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (mode_i[i]) pend_d[i] = adj[i];
      else           pend_d[i] = rise[i] | (pend_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R4
    edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!mode_i[i] && clr_i[i] && !rise[i]) |=> !pend_q[i]);
    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
      mode_i[i] |=> (pend_q[i] == $past(adj[i])));
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] cand_i,
  input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
  output logic               win_valid_o,
  output logic [IDX_W-1:0]   win_idx_o
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    best        = '1;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      // strict compare keeps the lower index on a tie
      if (cand_i[i] && (!win_valid_o || prio_i[i] < best)) begin
        win_valid_o = 1'b1;
        best        = prio_i[i];
        win_idx_o   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && win_valid_o) begin
      // R7
      win_is_cand_chk: assert (cand_i[win_idx_o]);
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cand_i[i]) begin
          // R7
          win_lowest_chk: assert (prio_i[i] >= prio_i[win_idx_o]);
          // R8
          tie_low_idx_chk: assert (prio_i[i] != prio_i[win_idx_o] || i >= int'(win_idx_o));
        end
      end
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W = 8,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               win_valid_i,
  input  logic [IDX_W-1:0]   win_idx_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] mode_o,
  output logic [NUM_SRC-1:0] route_o,
  output logic [1:0]         gmask_o,
  output logic [PRIO_W-1:0]  prio_o [NUM_SRC],
  output logic [NUM_SRC-1:0] clr_o
);
  localparam int SPW    = REG_W / PRIO_W;
  localparam int PWORDS = (NUM_SRC + SPW - 1) / SPW;

  logic [NUM_SRC-1:0] en_q, pol_q, mode_q, route_q;
  logic [1:0]         gmask_q;
  logic               vclr_q;
  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [REG_W-1:0]   pword [PWORDS];
  logic [REG_W-1:0]   rd_next;
  logic               wr, rd, rd_vec;

  assign wr     = sel_i & we_i;
  assign rd     = sel_i & ~we_i;
  assign rd_vec = rd && (addr_i == ADDR_W'(OFS_VEC));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0; pol_q <= '0; mode_q <= '0; route_q <= '0;
      gmask_q <= '0; vclr_q <= 1'b0;
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(OFS_EN))    en_q    <= wdata_i[NUM_SRC-1:0];
      if (addr_i == ADDR_W'(OFS_POL))   pol_q   <= wdata_i[NUM_SRC-1:0];
      if (addr_i == ADDR_W'(OFS_MODE))  mode_q  <= wdata_i[NUM_SRC-1:0];
      if (addr_i == ADDR_W'(OFS_ROUTE)) route_q <= wdata_i[NUM_SRC-1:0];
      if (addr_i == ADDR_W'(OFS_GMASK)) gmask_q <= wdata_i[1:0];
      if (addr_i == ADDR_W'(OFS_VCTRL)) vclr_q  <= wdata_i[REG_W-1];
      for (int i = 0; i < NUM_SRC; i++)
        if (addr_i == ADDR_W'(OFS_PRIO + i / SPW))
          prio_q[i] <= wdata_i[(i % SPW) * PRIO_W +: PRIO_W];
    end
  end

  for (genvar w = 0; w < PWORDS; w++) begin : g_pword
    for (genvar j = 0; j < SPW; j++) begin : g_slot
      if (w * SPW + j < NUM_SRC) begin : g_used
        assign pword[w][j*PRIO_W +: PRIO_W] = prio_q[w*SPW + j];
      end else begin : g_pad
        assign pword[w][j*PRIO_W +: PRIO_W] = '0;
      end
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr && addr_i == ADDR_W'(OFS_PEND)) clr_o = wdata_i[NUM_SRC-1:0];
    if (rd_vec && vclr_q && win_valid_i)   clr_o[win_idx_i] = 1'b1;
  end

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_W'(OFS_EN))    rd_next = REG_W'(en_q);
    if (addr_i == ADDR_W'(OFS_POL))   rd_next = REG_W'(pol_q);
    if (addr_i == ADDR_W'(OFS_MODE))  rd_next = REG_W'(mode_q);
    if (addr_i == ADDR_W'(OFS_ROUTE)) rd_next = REG_W'(route_q);
    if (addr_i == ADDR_W'(OFS_PEND))  rd_next = REG_W'(pend_i);
    if (addr_i == ADDR_W'(OFS_GMASK)) rd_next = REG_W'(gmask_q);
    if (addr_i == ADDR_W'(OFS_VCTRL)) rd_next = {vclr_q, {(REG_W-1){1'b0}}};
    if (addr_i == ADDR_W'(OFS_VEC))
      rd_next = {~win_valid_i, {(REG_W-1-IDX_W){1'b0}}, win_idx_i};
    for (int w = 0; w < PWORDS; w++)
      if (addr_i == ADDR_W'(OFS_PRIO + w)) rd_next = pword[w];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_o <= '0;
    else if (rd) rdata_o <= rd_next;
  end

  assign en_o = en_q; assign pol_o = pol_q; assign mode_o = mode_q;
  assign route_o = route_q; assign gmask_o = gmask_q; assign prio_o = prio_q;

  // R9
  vec_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && !win_valid_i) |=> (rdata_o == {1'b1, {(REG_W-1){1'b0}}}));
  // R9
  vec_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && win_valid_i) |=> !rdata_o[REG_W-1]);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W = 8,
  parameter int ADDR_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [REG_W-1:0]   bus_wdata_i,
  output logic [REG_W-1:0]   bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] en, pol, mode, route, clr, pend, irq_cand, fiq_cand;
  logic [1:0]         gmask;
  logic [PRIO_W-1:0]  prio [NUM_SRC];
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;

  intc_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .sel_i(bus_sel_i), .we_i(bus_we_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .pend_i(pend), .win_valid_i(win_valid), .win_idx_i(win_idx),
    .en_o(en), .pol_o(pol), .mode_o(mode), .route_o(route),
    .gmask_o(gmask), .prio_o(prio), .clr_o(clr));

  intc_detect #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) detect_i (
    .clk(clk), .rst(rst), .src_i(src_i), .pol_i(pol), .mode_i(mode),
    .clr_i(clr), .pend_o(pend));

  assign irq_cand = pend & en & route;
  assign fiq_cand = pend & en & ~route;

  intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
    .clk(clk), .rst(rst), .cand_i(irq_cand), .prio_i(prio),
    .win_valid_o(win_valid), .win_idx_o(win_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= gmask[0] & (|irq_cand);
      fiq_o <= gmask[1] & (|fiq_cand);
    end
  end

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(gmask[0]) |-> !irq_o);
  // R11
  fiq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(gmask[1]) |-> !fiq_o);
  // R2
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & en & route) == '0) |=> !irq_o);
  // R2
  fiq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & en & ~route) == '0) |=> !fiq_o);
endmodule

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic mon_due = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rst(rst), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq));

  // monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) mon_due <= sel && !we;
  always @(negedge clk) begin
    if (mon_due && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_tests++;
      if (rdata !== e.exp) begin
        n_fail++;
        $display("FAIL %s: read got %h expected %h", e.tag, rdata, e.exp);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t item;
    @(negedge clk);
    item.exp = e; item.tag = tag;
    sb_q.push_back(item);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic chk_out(input logic ei, input logic ef, input string tag);
    n_tests++;
    if (irq !== ei || fiq !== ef) begin
      n_fail++;
      $display("FAIL %s: irq/fiq got %b%b expected %b%b", tag, irq, fiq, ei, ef);
    end
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); src = src | m;
    wait_n(3);
    src = src & ~m;
    wait_n(2);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    // R1 reset state
    chk_out(0, 0, "R1 outputs");
    rd_exp(4'd0, 32'h0, "R1 enable");
    rd_exp(4'd4, 32'h0, "R1 pending");
    rd_exp(4'd5, 32'h0, "R1 gmask");
    rd_exp(4'd8, 32'h0, "R1 prio");
    rd_exp(4'd7, 32'h8000_0000, "R1 vector");

    wr_reg(4'd5, 32'h3);
    // R2 masked source still latches pending but drives nothing
    pulse(32'h8);
    wait_n(2);
    rd_exp(4'd4, 32'h8, "R2 pending latched while masked");
    chk_out(0, 0, "R2 masked source silent");
    wr_reg(4'd0, 32'h8);
    wait_n(1);
    chk_out(0, 1, "R6 route 0 to fiq");
    rd_exp(4'd7, 32'h8000_0000, "R9 fiq source not a vector");
    // R4 edge pending persists, then W1C
    rd_exp(4'd4, 32'h8, "R4 pending persists");
    wr_reg(4'd4, 32'h8);
    rd_exp(4'd4, 32'h0, "R4 w1c clears");
    wait_n(1);
    chk_out(0, 0, "R4 output drops after clear");

    // R6 route to irq, R10 read without clear
    wr_reg(4'd3, 32'h8);
    pulse(32'h8);
    wait_n(1);
    chk_out(1, 0, "R6 route 1 to irq");
    rd_exp(4'd7, 32'd3, "R9 vector reports source 3");
    rd_exp(4'd4, 32'h8, "R10 no clear when disarmed");
    // R11 global mask
    wr_reg(4'd5, 32'h2);
    wait_n(1);
    chk_out(0, 0, "R11 irq gated by bit0");
    wr_reg(4'd5, 32'h1);
    wait_n(1);
    chk_out(1, 0, "R11 irq passes with bit0");
    wr_reg(4'd5, 32'h3);
    wr_reg(4'd4, 32'h8);

    // R5 level mode on source 7
    wr_reg(4'd2, 32'h80);
    wr_reg(4'd3, 32'h88);
    wr_reg(4'd0, 32'h88);
    @(negedge clk); src[7] = 1'b1;
    wait_n(4);
    chk_out(1, 0, "R5 level active");
    rd_exp(4'd4, 32'h80, "R5 level pending");
    wr_reg(4'd4, 32'h80);
    rd_exp(4'd4, 32'h80, "R5 clear ignored in level");
    @(negedge clk); src[7] = 1'b0;
    wait_n(4);
    chk_out(0, 0, "R5 level released");
    rd_exp(4'd4, 32'h0, "R5 pending follows input");

    // R3 polarity on source 12 (level mode set before inversion)
    wr_reg(4'd2, 32'h1080);
    wr_reg(4'd3, 32'h1088);
    wr_reg(4'd0, 32'h1000);
    wr_reg(4'd1, 32'h1000);
    wait_n(4);
    chk_out(1, 0, "R3 active low asserts with input 0");
    rd_exp(4'd4, 32'h1000, "R3 inverted pending");
    @(negedge clk); src[12] = 1'b1;
    wait_n(4);
    chk_out(0, 0, "R3 active low idle with input 1");

    // R7 priority and packing, R10 clear on read
    wr_reg(4'd3, 32'h0030_0000);
    wr_reg(4'd0, 32'h0030_0000);
    wr_reg(4'd13, 32'h0000_0205);
    rd_exp(4'd13, 32'h0000_0205, "R7 priority word readback");
    wr_reg(4'd6, 32'h8000_0000);
    pulse(32'h0030_0000);
    wait_n(1);
    rd_exp(4'd7, 32'd21, "R7 lower value wins");
    rd_exp(4'd7, 32'd20, "R10 winner cleared, next reported");
    rd_exp(4'd7, 32'h8000_0000, "R10 all cleared");
    rd_exp(4'd4, 32'h0, "R10 pending empty");

    // R8 tie breaks to lower index
    wr_reg(4'd13, 32'h0000_0404);
    pulse(32'h0030_0000);
    wait_n(1);
    rd_exp(4'd7, 32'd20, "R8 tie lower index");
    rd_exp(4'd7, 32'd21, "R8 then higher index");
    wait_n(1);
    chk_out(0, 0, "R10 outputs idle after reads");

    // R12 latency
    @(negedge clk); src[20] = 1'b1;
    wait_n(3);
    chk_out(0, 0, "R12 not before edge 4");
    wait_n(1);
    chk_out(1, 0, "R12 at edge 4");

    wait_n(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule